// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire serial link. The wires are a serial output, a serial input and a shift clock. A single shift register sends its most significant bit first and fills with the incoming bits from its low end. After a complete transfer, the parallel read port holds the byte that arrived.

The block can run as clock master or as clock slave. As master it makes the shift clock itself by dividing the system clock by 2, 4 or 8. As slave it takes the shift clock from outside. It passes that clock through a two-flop synchroniser and finds its edges in the system clock domain, so the external clock must run slower than a quarter of the system clock. Software starts a transfer by setting a busy bit. The hardware clears that bit after eight clock pulses. Software may also clear it early to move fewer bits. A phase bit chooses which edge samples the input and which edge drives the output. In both phases the shift clock idles low.

Top module: `serlink_shift8`

## Requirements
- R1: In master mode the shift clock period P is 2, 4 or 8 system cycles for `div_sel` 00, 01 and 1x. A full transfer keeps `busy` high for 8*P cycles, and `sk_out` is high for P/2 cycles in each of its 8 pulses.
- R2: A `busy_set` pulse starts a transfer only while `busy` is low and the shift clock is low. `busy` drops after the eighth falling edge of the shift clock.
- R3: A `busy_clr` pulse ends the transfer on the next clock edge and moves no further bits. After N completed pulses, `rd_data` equals the loaded byte shifted left by N, with the first N received bits in its low end.
- R4: When `irq_en` is 1, `irq` is high for exactly one cycle, in the first cycle that `busy` is low after a full eight-bit transfer. `irq` stays low after an aborted transfer, and stays low whenever `irq_en` is 0.
- R5: In master mode `sk_out` is low whenever no transfer is running. From the second cycle after `busy` drops it stays low.
- R6: Normal phase (`phase_alt`=0): `si` is sampled on the shift clock rising edge and `so_out` changes on its falling edge. Bits are sent MSB first. After a full transfer `rd_data` holds the received byte.
- R7: Alternate phase (`phase_alt`=1): `si` is sampled on the falling edge and `so_out` changes on the rising edge. Bit order and the final `rd_data` are the same as in R6.
- R8: After reset `busy`, `irq`, `sk_out`, `so_out` and `rd_data` are all 0.
- R9: `so_oe` follows `so_en`. `sk_oe` is 1 in master mode and 0 in slave mode.
- R10: In slave mode a transfer is clocked by `sk_in` through the synchroniser. `busy` drops after eight external pulses.
- R11: `load_we` writes `load_data` into the shift register, with `rd_data` showing it one cycle later, only while the shift clock (the synchronised `sk_in` in slave mode) is low. A load or a `busy_set` while that clock is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1: internal shift clock; 0: external shift clock |
| so_en | input | 1 | Serial output enable request |
| div_sel | input | 2 | Master clock divide select |
| phase_alt | input | 1 | 0: normal phase; 1: alternate phase |
| irq_en | input | 1 | Enable for the completion interrupt |
| load_we | input | 1 | Parallel load strobe |
| load_data | input | 8 | Parallel load byte |
| busy_set | input | 1 | Start a transfer |
| busy_clr | input | 1 | Abort the transfer in progress |
| si | input | 1 | Serial data input |
| sk_in | input | 1 | External shift clock (slave mode) |
| so_out | output | 1 | Serial data output value |
| so_oe | output | 1 | Serial output drive enable |
| sk_out | output | 1 | Internal shift clock (master mode) |
| sk_oe | output | 1 | Shift clock drive enable |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 8 | Shift register contents |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Each check is timed to the cycle its result is due.
- Timing of R1 (master mode): `busy` shows 1 one cycle after the edge that takes `busy_set`. It stays high for exactly 8*P sampled cycles. `irq` appears in the same cycle that `busy` first reads 0, and `sk_out` must read low in the cycle after that.
- Timing of R11 (load): a parallel load appears on `rd_data` one cycle after the strobe.
- Slave mode: an edge on `sk_in` takes effect two to three system cycles later. The bench therefore keeps each external half-period at eight cycles. It samples `so_out` just before it moves the opposite clock edge, and it changes `si` only on the edge the block does not sample on.
- Sampling method: all outputs are read at the falling system clock edge. The bench acts as the link partner from the shift clock transitions it sees, so every count it makes comes from observed edges.

// File: rtl/sl_pkg.sv
package sl_pkg;

    // Half-period timer of the master clock: largest half period is 4 cycles
    localparam int unsigned HALF_MAX = 4;
    localparam int unsigned TMR_W    = $clog2(HALF_MAX);

    // Pair of single-cycle shift clock edge events
    typedef struct packed {
        logic rise;
        logic fall;
    } sk_edge_t;

    // Terminal count of the half-period timer for each divide select
    function automatic logic [TMR_W-1:0] half_limit(input logic [1:0] sel);
        logic [TMR_W-1:0] lim;
        case (sel)
            2'b00:   lim = TMR_W'(0);
            2'b01:   lim = TMR_W'(1);
            default: lim = TMR_W'(HALF_MAX - 1);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/sl_master_clk.sv
module sl_master_clk
    import sl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       sk,
    output sk_edge_t   ev
);

    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] lim;
    logic             expire;

    assign lim     = half_limit(div_sel);
    assign expire  = run && (tmr == lim);
    assign ev.rise = expire && !sk;
    assign ev.fall = expire && sk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr <= '0;
            sk  <= 1'b0;
        end else if (expire) begin
            tmr <= '0;
            sk  <= ~sk;
        end else begin
            tmr <= tmr + TMR_W'(1);
        end
    end

    // R5
    sk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !sk);

    // R1
    sk_rise_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sk) |-> $past(run));

endmodule

// File: rtl/sl_slave_sync.sv
module sl_slave_sync
    import sl_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sk_in,
    output logic     level,
    output sk_edge_t ev
);

    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], sk_in};
        end
    end

    assign level   = pipe[STAGES-1];
    assign ev.rise = pipe[STAGES-1] && !pipe[STAGES];
    assign ev.fall = !pipe[STAGES-1] && pipe[STAGES];

    // R10
    slave_rise_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> !ev.rise);

endmodule

// File: rtl/sl_shift_core.sv
module sl_shift_core
    import sl_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_alt,
    input  logic              sk_low,
    input  sk_edge_t          ev,
    input  logic              si,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_data,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic              irq_en,
    output logic              busy,
    output logic [DATA_W-1:0] data_q,
    output logic              so_bit,
    output logic              irq
);

    localparam int unsigned      CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              cap;
        logic              so_q;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              irq;
    } core_st_t;

    core_st_t st;
    core_st_t nx;
    logic     done;
    logic     load_ok;

    assign done    = st.busy && ev.fall && (st.cnt == LAST);
    assign load_ok = load_we && sk_low;

    always_comb begin
        nx     = st;
        nx.irq = 1'b0;
        if (st.busy) begin
            if (ev.rise) begin
                if (phase_alt) begin
                    nx.so_q = st.sr[DATA_W-1];
                    nx.sr   = {st.sr[DATA_W-2:0], 1'b0};
                end else begin
                    nx.cap  = si;
                end
            end
            if (ev.fall) begin
                nx.cnt = st.cnt + CNT_W'(1);
                if (phase_alt) begin
                    nx.sr[0] = si;
                end else begin
                    nx.sr = {st.sr[DATA_W-2:0], st.cap};
                end
            end
        end
        if (load_ok) begin
            nx.sr = load_data;
        end
        if (busy_clr) begin
            nx.busy = 1'b0;
        end else if (done) begin
            nx.busy = 1'b0;
            nx.irq  = irq_en;
        end else if (busy_set && !st.busy && sk_low) begin
            nx.busy = 1'b1;
            nx.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nx;
        end
    end

    assign busy   = st.busy;
    assign data_q = st.sr;
    assign so_bit = phase_alt ? st.so_q : st.sr[DATA_W-1];
    assign irq    = st.irq;

    // R2
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ev.fall && st.cnt == LAST && !busy_clr) |=> !busy);

    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_set && !busy && sk_low && !busy_clr) |=> busy);

    // R3
    abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
        busy_clr |=> !busy);

    // R4
    irq_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && $past(busy)));

    // R11
    load_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (load_we && !sk_low && !busy) |=> (data_q == $past(data_q)));

endmodule

// File: rtl/serlink_shift8.sv
module serlink_shift8
    import sl_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_master,
    input  logic              so_en,
    input  logic [1:0]        div_sel,
    input  logic              phase_alt,
    input  logic              irq_en,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_data,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic              si,
    input  logic              sk_in,
    output logic              so_out,
    output logic              so_oe,
    output logic              sk_out,
    output logic              sk_oe,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic     m_sk;
    sk_edge_t m_ev;
    logic     s_level;
    sk_edge_t s_ev;
    sk_edge_t ev;
    logic     sk_low;
    logic     run;

    assign run = busy && mode_master;

    sl_master_clk u_mclk (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_sel (div_sel),
        .sk      (m_sk),
        .ev      (m_ev)
    );

    sl_slave_sync #(.STAGES(SYNC_STAGES)) u_ssync (
        .clk   (clk),
        .rst   (rst),
        .sk_in (sk_in),
        .level (s_level),
        .ev    (s_ev)
    );

    assign ev     = mode_master ? m_ev : s_ev;
    assign sk_low = mode_master ? !m_sk : !s_level;

    sl_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .phase_alt (phase_alt),
        .sk_low    (sk_low),
        .ev        (ev),
        .si        (si),
        .load_we   (load_we),
        .load_data (load_data),
        .busy_set  (busy_set),
        .busy_clr  (busy_clr),
        .irq_en    (irq_en),
        .busy      (busy),
        .data_q    (rd_data),
        .so_bit    (so_out),
        .irq       (irq)
    );

    assign sk_out = m_sk;
    assign sk_oe  = mode_master;
    assign so_oe  = so_en;

    // R5
    top_sk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !sk_out);

endmodule

// File: tb/serlink_shift8_tb_top.sv
module serlink_shift8_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_master = 1'b1;
    logic       so_en = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       phase_alt = 1'b0;
    logic       irq_en = 1'b0;
    logic       load_we = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       busy_set = 1'b0;
    logic       busy_clr = 1'b0;
    logic       si = 1'b0;
    logic       sk_in = 1'b0;
    logic       so_out, so_oe, sk_out, sk_oe, busy, irq;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    serlink_shift8 dut_i (
        .clk(clk), .rst(rst), .mode_master(mode_master), .so_en(so_en),
        .div_sel(div_sel), .phase_alt(phase_alt), .irq_en(irq_en),
        .load_we(load_we), .load_data(load_data), .busy_set(busy_set),
        .busy_clr(busy_clr), .si(si), .sk_in(sk_in), .so_out(so_out),
        .so_oe(so_oe), .sk_out(sk_out), .sk_oe(sk_oe), .busy(busy),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic load_byte(input logic [7:0] b);
        load_data = b;
        load_we   = 1'b1;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    task automatic run_master(input logic [1:0] dsel, input logic alt,
                              input logic [7:0] tx, input logic [7:0] rx,
                              input logic ien, input int abort_n);
        int p;
        int busy_cyc;
        int hi;
        int pulses;
        int irq_seen;
        int guard;
        logic prev;
        logic [7:0] txs;
        logic [7:0] exp_rd;
        string ptag;
        p = (dsel == 2'b00) ? 2 : ((dsel == 2'b01) ? 4 : 8);
        ptag = alt ? "R7" : "R6";
        mode_master = 1'b1;
        div_sel     = dsel;
        phase_alt   = alt;
        irq_en      = ien;
        load_byte(tx);
        chk("R11", "master load", int'(rd_data), int'(tx));
        si = alt ? 1'b0 : rx[7];
        busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk("R2", "busy after set", int'(busy), 1);
        busy_cyc = 0; hi = 0; pulses = 0; irq_seen = 0; guard = 0;
        prev = 1'b0; txs = 8'h00;
        while (busy && guard < 200) begin
            guard++;
            busy_cyc++;
            if (sk_out && !prev) begin
                txs = {txs[6:0], so_out};
                if (alt) si = rx[7-pulses];
            end
            if (!sk_out && prev) begin
                pulses++;
                if (!alt && pulses < 8) si = rx[7-pulses];
                if (abort_n != 0 && pulses == abort_n) busy_clr = 1'b1;
            end
            if (sk_out) hi++;
            if (irq) irq_seen++;
            prev = sk_out;
            @(negedge clk);
            busy_clr = 1'b0;
        end
        if (prev && !sk_out) pulses++;
        if (abort_n == 0) begin
            chk("R1", "busy cycles", busy_cyc, 8 * p);
            chk("R1", "sk high cycles", hi, 4 * p);
            chk("R2", "pulse count", pulses, 8);
            chk(ptag, "bits sent", int'(txs), int'(tx));
            chk(ptag, "byte received", int'(rd_data), int'(rx));
            chk("R4", "irq at completion", int'(irq), int'(ien));
        end else begin
            exp_rd = (tx << abort_n) | (rx >> (8 - abort_n));
            chk("R3", "abort busy cycles", busy_cyc, abort_n * p + 1);
            chk("R3", "abort pulses", pulses, abort_n);
            chk("R3", "partial byte", int'(rd_data), int'(exp_rd));
            chk("R4", "no irq on abort", int'(irq), 0);
        end
        chk("R4", "no irq while busy", irq_seen, 0);
        @(negedge clk);
        chk("R5", "sk idle low", int'(sk_out), 0);
        chk("R4", "irq one cycle", int'(irq), 0);
    endtask

    task automatic run_slave(input logic alt, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] txs;
        string ptag;
        ptag = alt ? "R7" : "R6";
        mode_master = 1'b0;
        phase_alt   = alt;
        irq_en      = 1'b1;
        sk_in       = 1'b0;
        repeat (4) @(negedge clk);
        load_byte(tx);
        chk("R11", "slave load", int'(rd_data), int'(tx));
        si = alt ? 1'b0 : rx[7];
        busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk("R10", "slave busy after set", int'(busy), 1);
        txs = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (!alt) txs = {txs[6:0], so_out};
            sk_in = 1'b1;
            if (alt) si = rx[7-i];
            repeat (8) @(negedge clk);
            if (alt) txs = {txs[6:0], so_out};
            if (i == 7) chk("R10", "busy before last fall", int'(busy), 1);
            sk_in = 1'b0;
            if (!alt && i < 7) si = rx[6-i];
            repeat (8) @(negedge clk);
        end
        chk("R10", "slave busy done", int'(busy), 0);
        chk(ptag, "slave bits sent", int'(txs), int'(tx));
        chk("R10", "slave byte received", int'(rd_data), int'(rx));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8", "busy", int'(busy), 0);
        chk("R8", "irq", int'(irq), 0);
        chk("R8", "sk_out", int'(sk_out), 0);
        chk("R8", "so_out", int'(so_out), 0);
        chk("R8", "rd_data", int'(rd_data), 0);

        // R9 enables
        for (int k = 0; k < 4; k++) begin
            so_en       = k[0];
            mode_master = k[1];
            #1;
            chk("R9", "so_oe", int'(so_oe), int'(k[0]));
            chk("R9", "sk_oe", int'(sk_oe), int'(k[1]));
        end
        mode_master = 1'b1;
        @(negedge clk);

        // R1 R6 R7 sweep over dividers, phases and data
        for (int d = 0; d < 4; d++) begin
            for (int a = 0; a < 2; a++) begin
                for (int i = 0; i < 4; i++) begin
                    run_master(2'(d), a[0], 8'(i * 73 + 17 + d * 11), 8'(i * 29 + 200 + a * 5),
                               i[0], 0);
                end
            end
        end

        // R3 aborted transfers
        for (int a = 0; a < 2; a++) begin
            for (int n = 1; n < 8; n += 2) begin
                run_master(2'b01, a[0], 8'hA5, 8'h3C ^ 8'(n), 1'b1, n);
            end
        end

        // R10 slave transfers
        for (int a = 0; a < 2; a++) begin
            run_slave(a[0], 8'hC6, 8'h59);
            run_slave(a[0], 8'h1E, 8'hE3);
        end

        // R11 load and start ignored while external clock high
        mode_master = 1'b0;
        load_byte(8'h77);
        sk_in = 1'b1;
        repeat (4) @(negedge clk);
        load_byte(8'h3C);
        chk("R11", "load ignored while sk high", int'(rd_data), 'h77);
        busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk("R11", "start ignored while sk high", int'(busy), 0);
        sk_in = 1'b0;
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end

endmodule